// File: doc/BRIEF.md
# UART Receive Register Bank

This block is the register front end of a serial receiver. A small CSR bus (4-bit address, 8-bit data) reaches three registers. The first is a read-write baud divisor whose stored value drives the receiver's divisor input at all times. The second is a read-only status byte. The third is a read-only data byte, and reading it consumes the oldest received character.

The receiver itself sits outside the block. It offers each character as a byte plus an error bit with a valid signal. The block takes the character only when its 16-entry receive queue has room, and it reports that room back on a ready output. Each queue entry keeps the byte and its error bit together. The status register shows whether the queue holds anything, and it shows the error bit of the entry at the head.

Reads are combinational. The read data is valid in the same cycle as the read strobe. A read of the data register removes the head entry at the closing clock edge of that cycle.

Top module: `uart_rx_csr_bank`

## Requirements
- R1: After reset, `divisor` equals the parameter DIV_RESET (default 54), `rx_ready` is 1 and the status register reads 0x00.
- R2: A write at address 0 loads `csr_wdata[DIV_W-1:0]` into the divisor. `divisor` shows the new value from the cycle after the write. A read at address 0 returns the stored divisor, zero-extended to 8 bits.
- R3: A read at address 3 returns the status byte. Bit 0 is 1 when the queue holds at least one entry. Bit 4 is the error bit of the head entry. Bits 1-3 and 5-7 read 0.
- R4: A read at address 4 on a non-empty queue returns the head byte in that cycle and removes the head entry at the same clock edge. Entries come out in arrival order.
- R5: A read at address 4 on an empty queue returns 0x00 and removes nothing.
- R6: A character offered with `rx_valid` is stored only in a cycle where `rx_ready` is 1. `rx_ready` is 0 exactly when 16 entries are held. A read of address 4 and a store may happen in the same cycle.
- R7: Addresses other than 0, 3 and 4 read 0x00, and writes to them change nothing.
- R8: Writes to address 3 or 4 change neither the divisor nor the queue contents.
- R9: `csr_rdata` is 0x00 in any cycle where `csr_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 4 | Register address |
| csr_rd | input | 1 | Read strobe, one cycle per access |
| csr_wr | input | 1 | Write strobe, one cycle per access |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, valid while `csr_rd` is high |
| rx_valid | input | 1 | Receiver offers a character |
| rx_byte | input | 8 | Offered character |
| rx_err | input | 1 | Error flag of the offered character |
| rx_ready | output | 1 | Queue has room; acknowledges the receiver |
| divisor | output | DIV_W | Stored baud divisor driven to the receiver |

## Verification
Read data and `rx_ready` are combinational, so they are due in the same cycle as the read strobe or queue state that produces them. The bench samples them 1 ns after driving its inputs on the falling edge, before the next rising edge. A pop, a store or a divisor write takes effect at the following rising edge. The bench therefore checks `divisor` 1 ns after that edge, and checks queue effects through the next status or data read. The scoreboard queue is updated only on accepted characters and on data reads of a non-empty queue, which mirrors the cycle in which the block itself changes state.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIV  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'd4;

  localparam int STAT_AVAIL_BIT = 0;
  localparam int STAT_ERR_BIT   = 4;

  typedef struct packed {
    logic              err;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic [DATA_W-1:0] status_byte(input logic avail, input logic err);
    logic [DATA_W-1:0] s;
    s = '0;
    s[STAT_AVAIL_BIT] = avail;
    s[STAT_ERR_BIT]   = err;
    return s;
  endfunction
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import uart_csr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              sel_div,
  output logic              sel_stat,
  output logic              sel_data,
  output logic              div_we,
  output logic              data_re
);
  always_comb begin
    sel_div  = (addr == OFS_DIV);
    sel_stat = (addr == OFS_STAT);
    sel_data = (addr == OFS_DATA);
    div_we   = wr && sel_div;
    data_re  = rd && sel_data;
  end
endmodule

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import uart_csr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_en,
  input  rx_entry_t     w_entry,
  output logic          w_rdy,
  input  logic          r_en,
  output rx_entry_t     r_entry,
  output logic          r_rdy,
  output logic [CW-1:0] fill,
  output logic          push,
  output logic          pop
);
  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign w_rdy   = (fill != CW'(DEPTH));
  assign r_rdy   = (fill != '0);
  assign push    = w_en && w_rdy;
  assign pop     = r_en && r_rdy;
  assign r_entry = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= w_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_csr_bank.sv
module uart_rx_csr_bank
  import uart_csr_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = 8'd54,
  parameter int               DEPTH     = 16,
  localparam int              CW        = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_rd,
  input  logic              csr_wr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_err,
  output logic              rx_ready,
  output logic [DIV_W-1:0]  divisor
);
  logic          sel_div, sel_stat, sel_data, div_we, data_re;
  rx_entry_t     head;
  logic          head_vld;
  logic [CW-1:0] fifo_fill;
  logic          push_evt, pop_evt;

  csr_addr_decode u_dec (
    .addr(csr_addr), .rd(csr_rd), .wr(csr_wr),
    .sel_div(sel_div), .sel_stat(sel_stat), .sel_data(sel_data),
    .div_we(div_we), .data_re(data_re)
  );

  baud_div_reg #(.WIDTH(DIV_W), .INIT(DIV_RESET)) u_div (
    .clk(clk), .rst_n(rst_n), .we(div_we),
    .wdata(csr_wdata[DIV_W-1:0]), .q(divisor)
  );

  rx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .w_en(rx_valid), .w_entry('{err: rx_err, data: rx_byte}), .w_rdy(rx_ready),
    .r_en(data_re), .r_entry(head), .r_rdy(head_vld),
    .fill(fifo_fill), .push(push_evt), .pop(pop_evt)
  );

  always_comb begin
    csr_rdata = '0;
    if (csr_rd) begin
      if (sel_div)                    csr_rdata = DATA_W'(divisor);
      else if (sel_stat)              csr_rdata = status_byte(head_vld, head_vld && head.err);
      else if (sel_data && head_vld)  csr_rdata = head.data;
    end
  end
endmodule

// File: rtl/uart_rx_csr_bank_chk.sv
module uart_rx_csr_bank_chk #(
  parameter int DIV_W = 8,
  parameter int DEPTH = 16,
  localparam int CW   = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       csr_addr,
  input logic             csr_rd,
  input logic             csr_wr,
  input logic [7:0]       csr_wdata,
  input logic [7:0]       csr_rdata,
  input logic             rx_ready,
  input logic [DIV_W-1:0] divisor,
  input logic [CW-1:0]    fifo_fill,
  input logic             push_evt,
  input logic             pop_evt
);
  p_div_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == 4'd0) |=> divisor == $past(csr_wdata[DIV_W-1:0]));

  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && csr_addr == 4'd0) |=> $stable(divisor));

  p_status_resv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == 4'd3) |-> (csr_rdata[3:1] == 3'b0 && csr_rdata[7:5] == 3'b0));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == 4'd4 && fifo_fill == '0) |-> (csr_rdata == 8'h00 && !pop_evt));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_fill == CW'(DEPTH)) |-> !rx_ready);

  p_pop_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> fifo_fill == $past(fifo_fill) - 1'b1);

  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |-> csr_rdata == 8'h00);

  p_no_stray_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_rd && csr_addr == 4'd4) |-> !pop_evt);
endmodule

bind uart_rx_csr_bank uart_rx_csr_bank_chk #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_ready(rx_ready), .divisor(divisor),
  .fifo_fill(fifo_fill), .push_evt(push_evt), .pop_evt(pop_evt)
);

// File: tb/uart_rx_csr_bank_test.sv
`timescale 1ns/1ps
module uart_rx_csr_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] csr_addr = '0;
  logic       csr_rd = 1'b0, csr_wr = 1'b0;
  logic [7:0] csr_wdata = '0, csr_rdata;
  logic       rx_valid = 1'b0, rx_err = 1'b0, rx_ready;
  logic [7:0] rx_byte = '0, divisor;

  int total = 0, bad = 0;
  logic [8:0] exp_q[$];
  logic [7:0] s_rdata;
  logic       s_ready;

  uart_rx_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_err(rx_err), .rx_ready(rx_ready), .divisor(divisor)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bus/receiver cycle; samples combinational outputs before the rising edge
  task automatic cyc(input logic rd, input logic wr, input logic [3:0] a, input logic [7:0] wd,
                     input logic rv, input logic [7:0] rb, input logic re);
    @(negedge clk);
    csr_rd = rd; csr_wr = wr; csr_addr = a; csr_wdata = wd;
    rx_valid = rv; rx_byte = rb; rx_err = re;
    #1;
    s_rdata = csr_rdata;
    s_ready = rx_ready;
    @(posedge clk);
    #1;
    csr_rd = 1'b0; csr_wr = 1'b0; rx_valid = 1'b0;
  endtask

  // driver: offers one character and records it if the queue should take it
  task automatic send(input logic [7:0] b, input logic e);
    logic exp_rdy;
    exp_rdy = (exp_q.size() < 16);
    cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, b, e);
    chk("R6 rx_ready", {15'b0, s_ready}, {15'b0, exp_rdy});
    if (s_ready) exp_q.push_back({e, b});
  endtask

  // monitor: status then data read, compared with the scoreboard head
  task automatic take(input string tag);
    logic [7:0] exp_st, exp_d;
    exp_st = 8'h00;
    exp_d  = 8'h00;
    if (exp_q.size() > 0) begin
      exp_st = {3'b0, exp_q[0][8], 3'b0, 1'b1};
      exp_d  = exp_q[0][7:0];
    end
    cyc(1'b1, 1'b0, 4'd3, 8'h00, 1'b0, 8'h00, 1'b0);
    chk({"R3 status ", tag}, {8'b0, s_rdata}, {8'b0, exp_st});
    cyc(1'b1, 1'b0, 4'd4, 8'h00, 1'b0, 8'h00, 1'b0);
    chk({exp_q.size() > 0 ? "R4 data " : "R5 empty data ", tag}, {8'b0, s_rdata}, {8'b0, exp_d});
    if (exp_q.size() > 0) void'(exp_q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 divisor reset", {8'b0, divisor}, 16'd54);
    cyc(1'b0, 1'b0, 4'd3, 8'h00, 1'b0, 8'h00, 1'b0);
    chk("R1 rx_ready reset", {15'b0, s_ready}, 16'd1);
    chk("R9 idle rdata", {8'b0, s_rdata}, 16'd0);
    take("reset");

    // divisor write and readback
    cyc(1'b0, 1'b1, 4'd0, 8'hA5, 1'b0, 8'h00, 1'b0);
    chk("R2 divisor write", {8'b0, divisor}, 16'h00A5);
    cyc(1'b1, 1'b0, 4'd0, 8'h00, 1'b0, 8'h00, 1'b0);
    chk("R2 divisor read", {8'b0, s_rdata}, 16'h00A5);

    // unmapped addresses
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 3 && a != 4) begin
        cyc(1'b0, 1'b1, 4'(a), 8'h3C, 1'b0, 8'h00, 1'b0);
        chk("R7 write ignored", {8'b0, divisor}, 16'h00A5);
        cyc(1'b1, 1'b0, 4'(a), 8'h00, 1'b0, 8'h00, 1'b0);
        chk("R7 read zero", {8'b0, s_rdata}, 16'h0000);
      end
    end

    // ordering and per-entry error bit
    send(8'h11, 1'b0);
    send(8'h22, 1'b1);
    send(8'h33, 1'b0);

    // writes to status/data: no pop, divisor unchanged
    cyc(1'b0, 1'b1, 4'd3, 8'hFF, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b1, 4'd4, 8'hFF, 1'b0, 8'h00, 1'b0);
    chk("R8 divisor after reg writes", {8'b0, divisor}, 16'h00A5);
    take("a");
    take("b");

    // read with simultaneous store
    cyc(1'b1, 1'b0, 4'd4, 8'h00, 1'b1, 8'h44, 1'b1);
    chk("R6 R4 concurrent read data", {8'b0, s_rdata}, {8'b0, exp_q[0][7:0]});
    chk("R6 concurrent ready", {15'b0, s_ready}, 16'd1);
    void'(exp_q.pop_front());
    exp_q.push_back({1'b1, 8'h44});
    take("c");
    take("drain");

    // empty read, then check nothing was lost
    take("empty");
    send(8'h5A, 1'b0);
    take("after empty");

    // fill to the limit and overflow
    for (int i = 0; i < 18; i++) send(8'(8'h80 + i), i[0]);
    chk("R6 queue depth", 16'(exp_q.size()), 16'd16);
    for (int i = 0; i < 17; i++) take("full drain");

    // reset restores the divisor
    rst_n = 1'b0;
    #3 rst_n = 1'b1;
    chk("R1 divisor after reset", {8'b0, divisor}, 16'd54);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule